// File: doc/BRIEF.md
# Condition-Code Branch Decision Unit

This is a combinational unit for a small 8-bit processor core. It decides whether a branch is taken and produces the next program counter. Its inputs are a 5-bit operation selector, the five condition-code flags (half-carry, interrupt mask, negative, zero, carry), the current level of the external interrupt request pin, the address of the instruction that follows the branch, a signed 8-bit displacement and an absolute jump address.

For relative branches the target is the following-instruction address plus the sign-extended displacement. When the condition fails, the program counter simply moves on to the next instruction. Branch-to-subroutine is always taken and also presents a return address. The two absolute jump forms take the supplied address unchanged. Stack pushes and instruction fetch are left to the surrounding core.

Top module: `branch_decide`

## Requirements
- R1: Selector codes 0x02 to 0x07 are compare branches. 0x02 is taken when C=0 and Z=0. 0x03 is taken when C=1 or Z=1. 0x04 (carry clear, also higher-or-same) is taken when C=0. 0x05 (carry set, also lower) is taken when C=1. 0x06 is taken when Z=0, and 0x07 when Z=1.
- R2: Code 0x00 is taken for every flag and pin state. Code 0x01 is never taken and always falls through.
- R3: Code 0x08 is taken when H=0 and 0x09 when H=1. Code 0x0A is taken when N=0 and 0x0B when N=1.
- R4: Code 0x0C is taken when I=0 and 0x0D when I=1.
- R5: Code 0x0E is taken when irq_pin is low and 0x0F when it is high. The pin is read directly, without going through any flag.
- R6: A taken relative branch (codes 0x00 to 0x0F, or 0x10) gives next_pc = seq_pc + sign-extended rel_off, modulo 2^16. The reach is -128 to +127.
- R7: Whenever taken is 0, next_pc equals seq_pc.
- R8: Codes 0x11 (jump) and 0x12 (jump to subroutine) drive taken=1 and next_pc = jmp_addr, whatever the flags and the displacement are.
- R9: Code 0x10 (branch to subroutine) is always taken and uses the relative target. call is 1 for codes 0x10 and 0x12 and 0 for every other code. ret_addr always equals seq_pc.
- R10: Codes 0x13 to 0x1F are not branches. They give taken=0, call=0 and next_pc = seq_pc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Branch operation selector |
| cc_h | input | 1 | Half-carry flag |
| cc_i | input | 1 | Interrupt mask flag |
| cc_n | input | 1 | Negative flag |
| cc_z | input | 1 | Zero flag |
| cc_c | input | 1 | Carry flag |
| irq_pin | input | 1 | Raw interrupt request pin level |
| seq_pc | input | 16 | Address of the following instruction |
| rel_off | input | 8 | Signed branch displacement |
| jmp_addr | input | 16 | Absolute effective address for jumps |
| taken | output | 1 | Branch or jump is performed |
| next_pc | output | 16 | New program counter |
| call | output | 1 | Operation is a subroutine call |
| ret_addr | output | 16 | Return address to be stacked |

## Verification
The bench sweeps every flag and pin combination through all sixteen conditional codes. A swapped pair polarity or a wrong flag choice would therefore show up as an inverted or misrouted branch. The higher and lower-or-same tests are checked with C and Z each set alone, because a unit that tested only carry would miss the case where Z alone is set. Displacements of 0x7F and 0x80 are applied across the 0xFFFF/0x0000 boundary, which exposes a unit that zero-extends the offset or adds it with too few bits. Jumps are given flags and displacements that would make a relative branch fall through, so a unit that let the condition gate an absolute jump would fail.

// File: rtl/branch_decide.sv
module branch_decide #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [4:0]      op_sel,
  input  logic            cc_h,
  input  logic            cc_i,
  input  logic            cc_n,
  input  logic            cc_z,
  input  logic            cc_c,
  input  logic            irq_pin,
  input  logic [PC_W-1:0] seq_pc,
  input  logic [OFF_W-1:0] rel_off,
  input  logic [PC_W-1:0] jmp_addr,
  output logic            taken,
  output logic [PC_W-1:0] next_pc,
  output logic            call,
  output logic [PC_W-1:0] ret_addr
);
  localparam int EXT_W = PC_W - OFF_W;
  localparam logic [4:0] OP_BSR = 5'h10;
  localparam logic [4:0] OP_JMP = 5'h11;
  localparam logic [4:0] OP_JSR = 5'h12;

  logic            pair_true;
  logic            is_cond;
  logic            is_abs;
  logic [PC_W-1:0] rel_target;

  assign ret_addr = seq_pc;

  always_comb begin
    // even code of each pair branches when its flag test is true, odd code on the opposite
    unique case (op_sel[3:1])
      3'd0: pair_true = 1'b1;
      3'd1: pair_true = ~(cc_c | cc_z);
      3'd2: pair_true = ~cc_c;
      3'd3: pair_true = ~cc_z;
      3'd4: pair_true = ~cc_h;
      3'd5: pair_true = ~cc_n;
      3'd6: pair_true = ~cc_i;
      default: pair_true = ~irq_pin;
    endcase

    is_cond    = ~op_sel[4];
    is_abs     = (op_sel == OP_JMP) || (op_sel == OP_JSR);
    rel_target = seq_pc + {{EXT_W{rel_off[OFF_W-1]}}, rel_off};

    taken = (is_cond & (pair_true ^ op_sel[0])) | (op_sel == OP_BSR) | is_abs;
    call  = (op_sel == OP_BSR) || (op_sel == OP_JSR);

    if (is_abs)     next_pc = jmp_addr;
    else if (taken) next_pc = rel_target;
    else            next_pc = seq_pc;

    assert_never_falls_through_R2: assert (op_sel != 5'h01 || (!taken && next_pc == seq_pc));
    assert_pin_low_branch_R5: assert (op_sel != 5'h0E || taken == !irq_pin);
    assert_displacement_R6: assert (!(taken && !is_abs) ||
      (next_pc - seq_pc) == {{EXT_W{rel_off[OFF_W-1]}}, rel_off});
    assert_not_taken_sequential_R7: assert (taken || next_pc == seq_pc);
    assert_jump_loads_address_R8: assert (!is_abs || (taken && next_pc == jmp_addr));
    assert_bsr_taken_R9: assert (op_sel != OP_BSR || (taken && call));
    assert_unused_idle_R10: assert (op_sel < 5'h13 || (!taken && !call));
  end
endmodule

// File: tb/branch_decide_test.sv
module branch_decide_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  op_sel;
  logic        cc_h, cc_i, cc_n, cc_z, cc_c, irq_pin;
  logic [15:0] seq_pc, jmp_addr;
  logic [7:0]  rel_off;
  logic        taken, call;
  logic [15:0] next_pc, ret_addr;

  int vectors = 0;
  int errors  = 0;

  branch_decide uut (
    .op_sel(op_sel), .cc_h(cc_h), .cc_i(cc_i), .cc_n(cc_n), .cc_z(cc_z),
    .cc_c(cc_c), .irq_pin(irq_pin), .seq_pc(seq_pc), .rel_off(rel_off),
    .jmp_addr(jmp_addr), .taken(taken), .next_pc(next_pc), .call(call),
    .ret_addr(ret_addr)
  );

  function automatic logic exp_taken(input logic [4:0] op, input logic [5:0] f);
    logic h, i, n, z, c, p;
    {h, i, n, z, c, p} = f;
    case (op)
      5'h00: return 1'b1;
      5'h01: return 1'b0;
      5'h02: return !c && !z;
      5'h03: return c || z;
      5'h04: return !c;
      5'h05: return c;
      5'h06: return !z;
      5'h07: return z;
      5'h08: return !h;
      5'h09: return h;
      5'h0A: return !n;
      5'h0B: return n;
      5'h0C: return !i;
      5'h0D: return i;
      5'h0E: return !p;
      5'h0F: return p;
      5'h10, 5'h11, 5'h12: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input string req, input logic [4:0] op, input logic [5:0] f,
                       input logic [15:0] spc, input logic [7:0] off, input logic [15:0] ja);
    logic        et, ec;
    logic [15:0] en;
    @(posedge clk);
    op_sel = op; {cc_h, cc_i, cc_n, cc_z, cc_c, irq_pin} = f;
    seq_pc = spc; rel_off = off; jmp_addr = ja;
    et = exp_taken(op, f);
    ec = (op == 5'h10) || (op == 5'h12);
    if (op == 5'h11 || op == 5'h12) en = ja;
    else if (et) en = spc + {{8{off[7]}}, off};
    else en = spc;
    @(negedge clk);
    vectors++;
    if (taken !== et || next_pc !== en || call !== ec || ret_addr !== spc) begin
      errors++;
      $display("FAIL %s op=%h flags=%b: taken=%b next=%h call=%b ret=%h expected taken=%b next=%h call=%b ret=%h",
               req, op, f, taken, next_pc, call, ret_addr, et, en, ec, spc);
    end
  endtask

  task automatic sweep(input string req, input logic [4:0] op);
    for (int f = 0; f < 64; f++) apply(req, op, f[5:0], 16'h4000 + 16'(f), 8'h10, 16'hBEEF);
  endtask

  task automatic test_idle_R10;
    apply("R10", 5'h1F, 6'h00, 16'h0000, 8'h00, 16'h0000);
    for (int op = 5'h13; op < 32; op++) apply("R10", op[4:0], 6'h3F, 16'h1234, 8'h80, 16'hFFFF);
  endtask

  task automatic test_compare_R1;
    for (int op = 2; op < 8; op++) sweep("R1", op[4:0]);
    apply("R1", 5'h02, 6'b000100, 16'h0100, 8'h05, 16'h0);
    apply("R1", 5'h03, 6'b000100, 16'h0100, 8'h05, 16'h0);
  endtask

  task automatic test_always_never_R2;
    sweep("R2", 5'h00);
    sweep("R2", 5'h01);
  endtask

  task automatic test_half_neg_R3;
    for (int op = 8; op < 12; op++) sweep("R3", op[4:0]);
  endtask

  task automatic test_mask_R4;
    sweep("R4", 5'h0C);
    sweep("R4", 5'h0D);
  endtask

  task automatic test_pin_R5;
    sweep("R5", 5'h0E);
    sweep("R5", 5'h0F);
  endtask

  task automatic test_target_R6;
    apply("R6", 5'h00, 6'h00, 16'h2000, 8'h7F, 16'h0);
    apply("R6", 5'h00, 6'h00, 16'h2000, 8'h80, 16'h0);
    apply("R6", 5'h00, 6'h00, 16'hFFF0, 8'h7F, 16'h0);
    apply("R6", 5'h00, 6'h00, 16'h0010, 8'h80, 16'h0);
    apply("R6", 5'h10, 6'h00, 16'hFFFF, 8'h01, 16'h0);
    apply("R6", 5'h00, 6'h00, 16'h0000, 8'hFF, 16'h0);
  endtask

  task automatic test_fallthrough_R7;
    apply("R7", 5'h01, 6'h00, 16'h3000, 8'h80, 16'h0);
    apply("R7", 5'h07, 6'h00, 16'hFFFF, 8'h7F, 16'h0);
    apply("R7", 5'h0F, 6'h00, 16'h8000, 8'h80, 16'h0);
  endtask

  task automatic test_jump_R8;
    for (int f = 0; f < 64; f += 21) begin
      apply("R8", 5'h11, f[5:0], 16'h1000, 8'h80, 16'hC0DE);
      apply("R8", 5'h12, f[5:0], 16'h1000, 8'h7F, 16'h0042);
    end
  endtask

  task automatic test_call_R9;
    sweep("R9", 5'h10);
    apply("R9", 5'h10, 6'h3F, 16'h0005, 8'hF0, 16'h0);
  endtask

  initial begin
    op_sel = 5'h1F; {cc_h, cc_i, cc_n, cc_z, cc_c, irq_pin} = 6'h0;
    seq_pc = 16'h0; rel_off = 8'h0; jmp_addr = 16'h0;
    test_idle_R10;
    test_compare_R1;
    test_always_never_R2;
    test_half_neg_R3;
    test_mask_R4;
    test_pin_R5;
    test_target_R6;
    test_fallthrough_R7;
    test_jump_R8;
    test_call_R9;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule